// File: doc/BRIEF.md
# Interrupt-Capable Memory-Mapped GPIO Controller

This block is a bank of general-purpose pins behind a simple 32-bit register bus with single-cycle access. Software drives pins through an output data register and a per-pin direction register. It reads pin levels through a synchronized input register. It can also raise or lower individual output bits atomically through two write-only ports, so it never needs a read-modify-write of the data register.

Each pin has its own interrupt detector. The trigger mode is built from three per-pin bits: type (level or edge), polarity (active level or edge direction) and a both-edges override. Detected events are gated per pin by an enable register. Edge events are held in a pending latch until software acknowledges them with a write-one-to-clear. The enabled events are visible in a status register, and the bits that the mask register leaves through are ORed into a single interrupt line. The pull and debounce registers are plain read/write storage for the pad ring and the filter logic outside the block.

Top module: `gpio_irq_unit`

## Requirements
- R1: Registers sit at these byte offsets: 0x00 output data, 0x04 input (read-only), 0x08 direction, 0x10 set (write-only), 0x14 clear (write-only), 0x18 pull enable, 0x1C pull select, 0x20 interrupt enable, 0x24 interrupt status (read-only), 0x2C interrupt mask, 0x30 interrupt acknowledge (write-only), 0x34 trigger type, 0x38 both-edges, 0x3C polarity, 0x40 debounce enable, 0x44 debounce prescale. Every read/write register reads back the last value written. Write-only and unmapped offsets read as zero. Writes to read-only or unmapped offsets change nothing.
- R2: A write to the set port ORs the written ones into the output data, and pins written with zero keep their value.
- R3: A write to the clear port forces to zero the output bits written with one, and pins written with zero keep their value.
- R4: padOut carries the output data register and padOe carries the direction register, where direction 1 means the pin is driven.
- R5: The input register returns every pad value after a two-flop synchronizer, output pins included. A pad change is readable from the second clock edge after it.
- R6: With trigger type 0 and both-edges 0, polarity 0 latches a pending event on a rising edge and polarity 1 latches one on a falling edge. The opposite edge latches nothing.
- R7: With trigger type 0 and both-edges 1, either edge latches a pending event, whatever the polarity bit.
- R8: With trigger type 1, the status bit follows the synchronized pin level: active-high for polarity 0 and active-low for polarity 1. Acknowledge writes do not clear it.
- R9: Writing one to an acknowledge bit removes that pin's latched edge event, and writing zero leaves it. An edge event in the same cycle as its acknowledge stays pending.
- R10: An interrupt enable bit of 0 stops new events from latching and hides the pin in the status register. With no enable bit set, irqOut stays low.
- R11: A mask bit of 1 removes the pin from irqOut but not from the status register. irqOut is the OR of status AND NOT mask.
- R12: After reset every register is zero, no event is pending, padOe and padOut are zero, and irqOut is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 8 | Byte address of the access |
| busWrEn | input | 1 | Write strobe; a low strobe is a read |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data for busAddr, combinational |
| padIn | input | 32 | Asynchronous pin levels from the pads |
| padOut | output | 32 | Output levels to the pads |
| padOe | output | 32 | Per-pin output enable to the pads |
| irqOut | output | 1 | Combined interrupt request |

## Verification
The edge-latch assertions assume that one bus access lands per cycle and that the address and strobe are stable around the clock edge. The bench drives the bus at the falling edge and holds each access for one full cycle. Pad changes that are meant to be counted as edges are always held for at least three cycles before the next change, so the synchronizer never swallows a pulse. The random phase changes pads only between register writes, with the pins settled. The acknowledge-collision case is then placed on purpose, with the clear write timed to land on the cycle in which the synchronized edge is detected.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  localparam int BUS_W  = 32;
  localparam int OFFS_W = 8;

  localparam logic [OFFS_W-1:0] OFF_DOUT    = 8'h00;
  localparam logic [OFFS_W-1:0] OFF_DIN     = 8'h04;
  localparam logic [OFFS_W-1:0] OFF_DIR     = 8'h08;
  localparam logic [OFFS_W-1:0] OFF_SET     = 8'h10;
  localparam logic [OFFS_W-1:0] OFF_CLR     = 8'h14;
  localparam logic [OFFS_W-1:0] OFF_PULLEN  = 8'h18;
  localparam logic [OFFS_W-1:0] OFF_PULLSEL = 8'h1C;
  localparam logic [OFFS_W-1:0] OFF_IEN     = 8'h20;
  localparam logic [OFFS_W-1:0] OFF_ISTAT   = 8'h24;
  localparam logic [OFFS_W-1:0] OFF_IMASK   = 8'h2C;
  localparam logic [OFFS_W-1:0] OFF_IACK    = 8'h30;
  localparam logic [OFFS_W-1:0] OFF_ITYPE   = 8'h34;
  localparam logic [OFFS_W-1:0] OFF_IBOTH   = 8'h38;
  localparam logic [OFFS_W-1:0] OFF_IPOL    = 8'h3C;
  localparam logic [OFFS_W-1:0] OFF_DBEN    = 8'h40;
  localparam logic [OFFS_W-1:0] OFF_DBPRE   = 8'h44;

  // One write strobe per writable register, raised by the control decoder
  typedef struct packed {
    logic wrDout;
    logic wrDir;
    logic wrSet;
    logic wrClr;
    logic wrPullEn;
    logic wrPullSel;
    logic wrIen;
    logic wrImask;
    logic wrIack;
    logic wrItype;
    logic wrIboth;
    logic wrIpol;
    logic wrDbEn;
    logic wrDbPre;
  } regStrobe_t;

  typedef enum logic [3:0] {
    RD_NONE,
    RD_DOUT,
    RD_DIN,
    RD_DIR,
    RD_PULLEN,
    RD_PULLSEL,
    RD_IEN,
    RD_ISTAT,
    RD_IMASK,
    RD_ITYPE,
    RD_IBOTH,
    RD_IPOL,
    RD_DBEN,
    RD_DBPRE
  } rdSel_t;

endpackage

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  output regStrobe_t        strobe,
  output rdSel_t            rdSel
);

  localparam int CMP_W = (ADDR_W < OFFS_W) ? ADDR_W : OFFS_W;

  function automatic logic hitOffset(input logic [ADDR_W-1:0] a,
                                     input logic [OFFS_W-1:0] off);
    logic match;
    match = (a[CMP_W-1:0] == off[CMP_W-1:0]);
    for (int i = CMP_W; i < ADDR_W; i++) begin
      if (a[i]) match = 1'b0;
    end
    return match;
  endfunction

  always_comb begin
    strobe           = '0;
    strobe.wrDout    = busWrEn && hitOffset(busAddr, OFF_DOUT);
    strobe.wrDir     = busWrEn && hitOffset(busAddr, OFF_DIR);
    strobe.wrSet     = busWrEn && hitOffset(busAddr, OFF_SET);
    strobe.wrClr     = busWrEn && hitOffset(busAddr, OFF_CLR);
    strobe.wrPullEn  = busWrEn && hitOffset(busAddr, OFF_PULLEN);
    strobe.wrPullSel = busWrEn && hitOffset(busAddr, OFF_PULLSEL);
    strobe.wrIen     = busWrEn && hitOffset(busAddr, OFF_IEN);
    strobe.wrImask   = busWrEn && hitOffset(busAddr, OFF_IMASK);
    strobe.wrIack    = busWrEn && hitOffset(busAddr, OFF_IACK);
    strobe.wrItype   = busWrEn && hitOffset(busAddr, OFF_ITYPE);
    strobe.wrIboth   = busWrEn && hitOffset(busAddr, OFF_IBOTH);
    strobe.wrIpol    = busWrEn && hitOffset(busAddr, OFF_IPOL);
    strobe.wrDbEn    = busWrEn && hitOffset(busAddr, OFF_DBEN);
    strobe.wrDbPre   = busWrEn && hitOffset(busAddr, OFF_DBPRE);
  end

  always_comb begin
    rdSel = RD_NONE;
    if      (hitOffset(busAddr, OFF_DOUT))    rdSel = RD_DOUT;
    else if (hitOffset(busAddr, OFF_DIN))     rdSel = RD_DIN;
    else if (hitOffset(busAddr, OFF_DIR))     rdSel = RD_DIR;
    else if (hitOffset(busAddr, OFF_PULLEN))  rdSel = RD_PULLEN;
    else if (hitOffset(busAddr, OFF_PULLSEL)) rdSel = RD_PULLSEL;
    else if (hitOffset(busAddr, OFF_IEN))     rdSel = RD_IEN;
    else if (hitOffset(busAddr, OFF_ISTAT))   rdSel = RD_ISTAT;
    else if (hitOffset(busAddr, OFF_IMASK))   rdSel = RD_IMASK;
    else if (hitOffset(busAddr, OFF_ITYPE))   rdSel = RD_ITYPE;
    else if (hitOffset(busAddr, OFF_IBOTH))   rdSel = RD_IBOTH;
    else if (hitOffset(busAddr, OFF_IPOL))    rdSel = RD_IPOL;
    else if (hitOffset(busAddr, OFF_DBEN))    rdSel = RD_DBEN;
    else if (hitOffset(busAddr, OFF_DBPRE))   rdSel = RD_DBPRE;
  end

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobe)) else $error("AST_ONE_STROBE"); // R1

endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
  parameter int NUM_PINS = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_PINS-1:0] syncIn,
  input  logic [NUM_PINS-1:0] intEn,
  input  logic [NUM_PINS-1:0] intType,
  input  logic [NUM_PINS-1:0] intBoth,
  input  logic [NUM_PINS-1:0] intPol,
  input  logic [NUM_PINS-1:0] ackMask,
  output logic [NUM_PINS-1:0] intStatus
);

  logic [NUM_PINS-1:0] prevIn;
  logic [NUM_PINS-1:0] edgeEvent;
  logic [NUM_PINS-1:0] edgeLatch;
  logic [NUM_PINS-1:0] levelActive;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevIn <= '0;
    else       prevIn <= syncIn;
  end

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    logic rise, fall, hit;
    always_comb begin
      rise = syncIn[p] & ~prevIn[p];
      fall = ~syncIn[p] & prevIn[p];
      if (intBoth[p]) hit = rise | fall;
      else            hit = intPol[p] ? fall : rise;
      edgeEvent[p]   = intEn[p] & ~intType[p] & hit;
      levelActive[p] = intType[p] & (syncIn[p] ^ intPol[p]);
      intStatus[p]   = intEn[p] & (intType[p] ? levelActive[p] : edgeLatch[p]);
    end

    // A new event in the acknowledge cycle wins over the acknowledge
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) edgeLatch[p] <= 1'b0;
      else       edgeLatch[p] <= (edgeLatch[p] & ~ackMask[p]) | edgeEvent[p];
    end
  end

  AST_EDGE_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (($past(edgeLatch) & ~$past(ackMask) & ~edgeLatch) == '0))
    else $error("AST_EDGE_STICKY"); // R9

  AST_ACK_TAKES: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((edgeLatch & $past(ackMask) & ~$past(edgeEvent)) == '0))
    else $error("AST_ACK_TAKES"); // R9

  AST_NO_LATCH_DISABLED: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((edgeLatch & ~$past(edgeLatch) & ~$past(intEn)) == '0))
    else $error("AST_NO_LATCH_DISABLED"); // R10

endmodule

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PINS    = 32,
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  regStrobe_t          strobe,
  input  rdSel_t              rdSel,
  input  logic [DATA_W-1:0]   busWrData,
  input  logic [NUM_PINS-1:0] padIn,
  input  logic [NUM_PINS-1:0] intStatus,
  output logic [DATA_W-1:0]   busRdData,
  output logic [NUM_PINS-1:0] padOut,
  output logic [NUM_PINS-1:0] padOe,
  output logic [NUM_PINS-1:0] syncIn,
  output logic [NUM_PINS-1:0] intEn,
  output logic [NUM_PINS-1:0] intType,
  output logic [NUM_PINS-1:0] intBoth,
  output logic [NUM_PINS-1:0] intPol,
  output logic [NUM_PINS-1:0] ackMask,
  output logic                irqOut
);

  logic [NUM_PINS-1:0] wrPins;
  logic [NUM_PINS-1:0] dataOut, dirReg, pullEn, pullSel, intMask, dbEn;
  logic [DATA_W-1:0]   dbPre;
  logic [NUM_PINS-1:0] syncChain [SYNC_STAGES];

  assign wrPins = busWrData[NUM_PINS-1:0];

  // Output data: direct write, atomic set, atomic clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              dataOut <= '0;
    else if (strobe.wrDout) dataOut <= wrPins;
    else if (strobe.wrSet)  dataOut <= dataOut | wrPins;
    else if (strobe.wrClr)  dataOut <= dataOut & ~wrPins;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dirReg  <= '0;
      pullEn  <= '0;
      pullSel <= '0;
      intEn   <= '0;
      intMask <= '0;
      intType <= '0;
      intBoth <= '0;
      intPol  <= '0;
      dbEn    <= '0;
      dbPre   <= '0;
    end else begin
      if (strobe.wrDir)     dirReg  <= wrPins;
      if (strobe.wrPullEn)  pullEn  <= wrPins;
      if (strobe.wrPullSel) pullSel <= wrPins;
      if (strobe.wrIen)     intEn   <= wrPins;
      if (strobe.wrImask)   intMask <= wrPins;
      if (strobe.wrItype)   intType <= wrPins;
      if (strobe.wrIboth)   intBoth <= wrPins;
      if (strobe.wrIpol)    intPol  <= wrPins;
      if (strobe.wrDbEn)    dbEn    <= wrPins;
      if (strobe.wrDbPre)   dbPre   <= busWrData;
    end
  end

  // Input synchronizer chain
  for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)       syncChain[s] <= '0;
      else if (s == 0) syncChain[s] <= padIn;
      else             syncChain[s] <= syncChain[(s == 0) ? 0 : s-1];
    end
  end
  assign syncIn = syncChain[SYNC_STAGES-1];

  assign ackMask = strobe.wrIack ? wrPins : '0;
  assign padOut  = dataOut;
  assign padOe   = dirReg;
  assign irqOut  = |(intStatus & ~intMask);

  function automatic logic [DATA_W-1:0] widen(input logic [NUM_PINS-1:0] v);
    logic [DATA_W-1:0] w;
    w = '0;
    w[NUM_PINS-1:0] = v;
    return w;
  endfunction

  always_comb begin
    unique case (rdSel)
      RD_DOUT:    busRdData = widen(dataOut);
      RD_DIN:     busRdData = widen(syncIn);
      RD_DIR:     busRdData = widen(dirReg);
      RD_PULLEN:  busRdData = widen(pullEn);
      RD_PULLSEL: busRdData = widen(pullSel);
      RD_IEN:     busRdData = widen(intEn);
      RD_ISTAT:   busRdData = widen(intStatus);
      RD_IMASK:   busRdData = widen(intMask);
      RD_ITYPE:   busRdData = widen(intType);
      RD_IBOTH:   busRdData = widen(intBoth);
      RD_IPOL:    busRdData = widen(intPol);
      RD_DBEN:    busRdData = widen(dbEn);
      RD_DBPRE:   busRdData = dbPre;
      default:    busRdData = '0;
    endcase
  end

  AST_SET_RAISES: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrSet |=> ((dataOut & $past(wrPins)) == $past(wrPins)))
    else $error("AST_SET_RAISES"); // R2

  AST_SET_KEEPS: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrSet |=> ((dataOut & ~$past(wrPins)) == ($past(dataOut) & ~$past(wrPins))))
    else $error("AST_SET_KEEPS"); // R2

  AST_CLR_LOWERS: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrClr |=> ((dataOut & $past(wrPins)) == '0))
    else $error("AST_CLR_LOWERS"); // R3

  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (intEn == '0) |-> !irqOut) else $error("AST_DISABLED_QUIET"); // R10

  AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (&intMask) |-> !irqOut) else $error("AST_MASKED_QUIET"); // R11

  AST_RESET_CLEAN: assert property (@(posedge clk) disable iff (!rstN)
    !$past(rstN) |-> (intStatus == '0 && dirReg == '0 && !irqOut))
    else $error("AST_RESET_CLEAN"); // R12

endmodule

// File: rtl/gpio_irq_unit.sv
module gpio_irq_unit
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PINS    = 32,
  parameter int ADDR_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic                busWrEn,
  input  logic [BUS_W-1:0]    busWrData,
  output logic [BUS_W-1:0]    busRdData,
  input  logic [NUM_PINS-1:0] padIn,
  output logic [NUM_PINS-1:0] padOut,
  output logic [NUM_PINS-1:0] padOe,
  output logic                irqOut
);

  regStrobe_t          strobe;
  rdSel_t              rdSel;
  logic [NUM_PINS-1:0] syncIn, intEn, intType, intBoth, intPol, ackMask, intStatus;

  gpio_irq_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .strobe(strobe), .rdSel(rdSel)
  );

  gpio_irq_regs #(.NUM_PINS(NUM_PINS), .DATA_W(BUS_W), .SYNC_STAGES(SYNC_STAGES)) regs_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .rdSel(rdSel),
    .busWrData(busWrData), .padIn(padIn), .intStatus(intStatus),
    .busRdData(busRdData), .padOut(padOut), .padOe(padOe), .syncIn(syncIn),
    .intEn(intEn), .intType(intType), .intBoth(intBoth), .intPol(intPol),
    .ackMask(ackMask), .irqOut(irqOut)
  );

  gpio_irq_detect #(.NUM_PINS(NUM_PINS)) detect_i (
    .clk(clk), .rstN(rstN), .syncIn(syncIn), .intEn(intEn),
    .intType(intType), .intBoth(intBoth), .intPol(intPol),
    .ackMask(ackMask), .intStatus(intStatus)
  );

endmodule

// File: tb/gpio_irq_unit_tb.sv
module gpio_irq_unit_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  busAddr = '0;
  logic        busWrEn = 1'b0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic [31:0] padIn = '0;
  logic [31:0] padOut, padOe;
  logic        irqOut;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // Reference model state
  logic [31:0] mDout, mDir, mPullEn, mPullSel, mIen, mImask;
  logic [31:0] mItype, mIboth, mIpol, mDbEn, mDbPre, mLatch, mPad;

  always #5 clk = ~clk;

  gpio_irq_unit dut_i (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdData(busRdData), .padIn(padIn),
    .padOut(padOut), .padOe(padOe), .irqOut(irqOut)
  );

  function automatic logic [31:0] expStatus();
    return mIen & ((mItype & (mPad ^ mIpol)) | (~mItype & mLatch));
  endfunction

  function automatic logic [31:0] expRead(input logic [7:0] a);
    case (a)
      8'h00: return mDout;
      8'h04: return mPad;
      8'h08: return mDir;
      8'h18: return mPullEn;
      8'h1C: return mPullSel;
      8'h20: return mIen;
      8'h24: return expStatus();
      8'h2C: return mImask;
      8'h34: return mItype;
      8'h38: return mIboth;
      8'h3C: return mIpol;
      8'h40: return mDbEn;
      8'h44: return mDbPre;
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [31:0] edgeHits(input logic [31:0] oldV, input logic [31:0] newV);
    logic [31:0] rise, fall;
    rise = newV & ~oldV;
    fall = ~newV & oldV;
    return mIen & ~mItype & ((mIboth & (rise | fall)) |
                             (~mIboth & ((mIpol & fall) | (~mIpol & rise))));
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic modelReset();
    mDout = '0; mDir = '0; mPullEn = '0; mPullSel = '0; mIen = '0; mImask = '0;
    mItype = '0; mIboth = '0; mIpol = '0; mDbEn = '0; mDbPre = '0; mLatch = '0; mPad = '0;
  endtask

  task automatic modelWrite(input logic [7:0] a, input logic [31:0] d);
    case (a)
      8'h00: mDout = d;
      8'h08: mDir = d;
      8'h10: mDout = mDout | d;
      8'h14: mDout = mDout & ~d;
      8'h18: mPullEn = d;
      8'h1C: mPullSel = d;
      8'h20: mIen = d;
      8'h2C: mImask = d;
      8'h30: mLatch = mLatch & ~d;
      8'h34: mItype = d;
      8'h38: mIboth = d;
      8'h3C: mIpol = d;
      8'h40: mDbEn = d;
      8'h44: mDbPre = d;
      default: ;
    endcase
  endtask

  task automatic busWrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(posedge clk);
    #1;
    busWrEn = 1'b0;
    modelWrite(a, d);
  endtask

  task automatic busRead(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWrEn = 1'b0;
    #1;
    d = busRdData;
  endtask

  task automatic setPads(input logic [31:0] v);
    @(negedge clk);
    padIn = v;
    mLatch = mLatch | edgeHits(mPad, v);
    mPad = v;
    repeat (3) @(posedge clk);
    #1;
  endtask

  task automatic readCheck(input string req, input logic [7:0] a);
    logic [31:0] d;
    busRead(a, d);
    check(req, d, expRead(a));
  endtask

  task automatic checkIrq(input string req);
    logic [31:0] st;
    st = expStatus();
    check(req, {31'h0, irqOut}, {31'h0, |(st & ~mImask)});
  endtask

  task automatic checkAll();
    logic [7:0] offs [17] = '{8'h00, 8'h04, 8'h08, 8'h10, 8'h14, 8'h18, 8'h1C, 8'h20,
                              8'h24, 8'h2C, 8'h30, 8'h34, 8'h38, 8'h3C, 8'h40, 8'h44, 8'h0C};
    foreach (offs[i]) readCheck("R1 readback", offs[i]);
    check("R4 padOut", padOut, mDout);
    check("R4 padOe", padOe, mDir);
    checkIrq("R11 irqOut");
  endtask

  // Watchdog
  initial begin
    #2ms;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [7:0]  wrOffs [16] = '{8'h00, 8'h04, 8'h08, 8'h10, 8'h14, 8'h18, 8'h1C, 8'h20,
                                 8'h24, 8'h2C, 8'h30, 8'h34, 8'h38, 8'h3C, 8'h40, 8'h44};
    int unsigned seed;
    seed = $urandom(32'h5eed_1234);
    modelReset();
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // R12: reset state
    check("R12 padOe", padOe, 32'h0);
    check("R12 padOut", padOut, 32'h0);
    check("R12 irqOut", {31'h0, irqOut}, 32'h0);
    checkAll();

    // R2 / R3: atomic set and clear
    busWrite(8'h00, 32'hA5A5_0F0F);
    busWrite(8'h10, 32'h0000_F0F0);
    readCheck("R2 set ORs", 8'h00);
    check("R2 value", mDout, 32'hA5A5_FFFF);
    busWrite(8'h14, 32'hA000_000F);
    readCheck("R3 clear", 8'h00);
    check("R3 value", mDout, 32'h05A5_FFF0);
    check("R4 padOut", padOut, 32'h05A5_FFF0);

    // R5: synchronized inputs, two edges of latency, output pins included
    busWrite(8'h08, 32'hFFFF_0000);
    @(negedge clk); padIn = 32'h1234_5678;
    @(posedge clk); #1; busAddr = 8'h04;
    #1 check("R5 not yet after 1 edge", busRdData, 32'h0);
    @(posedge clk); #2;
    check("R5 after 2 edges", busRdData, 32'h1234_5678);
    mPad = 32'h1234_5678;
    setPads(32'h0);

    // R6: rising / falling on pins 0 and 1
    busWrite(8'h3C, 32'h0000_0002);
    busWrite(8'h20, 32'h0000_0003);
    setPads(32'h0000_0003);
    readCheck("R6 rising latched", 8'h24);
    check("R6 status", expStatus(), 32'h1);
    setPads(32'h0);
    readCheck("R6 falling latched", 8'h24);
    checkIrq("R11 irq on pending");

    // R9: acknowledge removes, zero bits keep
    busWrite(8'h30, 32'h0000_0001);
    readCheck("R9 ack one pin", 8'h24);
    check("R9 remaining", expStatus(), 32'h2);
    busWrite(8'h30, 32'hFFFF_FFFF);
    readCheck("R9 ack all", 8'h24);

    // R7: both edges, polarity ignored
    busWrite(8'h38, 32'h0000_0004);
    busWrite(8'h3C, 32'h0000_0004);
    busWrite(8'h20, 32'h0000_0004);
    setPads(32'h0000_0004);
    readCheck("R7 rise with pol 1", 8'h24);
    busWrite(8'h30, 32'h0000_0004);
    setPads(32'h0);
    readCheck("R7 fall", 8'h24);
    check("R7 status", expStatus(), 32'h4);
    busWrite(8'h30, 32'hFFFF_FFFF);

    // R8: level, active-low on pin 5, ack has no effect
    busWrite(8'h34, 32'h0000_0020);
    busWrite(8'h3C, 32'h0000_0020);
    busWrite(8'h20, 32'h0000_0020);
    readCheck("R8 active-low asserted", 8'h24);
    busWrite(8'h30, 32'h0000_0020);
    readCheck("R8 ack ignored", 8'h24);
    check("R8 status", expStatus(), 32'h20);
    setPads(32'h0000_0020);
    readCheck("R8 follows level", 8'h24);

    // R11: mask hides from irq, not from status
    setPads(32'h0);
    busWrite(8'h2C, 32'h0000_0020);
    readCheck("R11 status unmasked view", 8'h24);
    check("R11 masked irq", {31'h0, irqOut}, 32'h0);
    busWrite(8'h2C, 32'h0);
    checkIrq("R11 unmasked irq");

    // R10: disabled pin latches nothing
    busWrite(8'h20, 32'h0);
    busWrite(8'h34, 32'h0);
    busWrite(8'h3C, 32'h0);
    busWrite(8'h38, 32'h0);
    setPads(32'h0000_0008);
    busWrite(8'h20, 32'h0000_0008);
    readCheck("R10 no latch while disabled", 8'h24);
    check("R10 irq", {31'h0, irqOut}, 32'h0);
    setPads(32'h0);

    // R9: edge colliding with acknowledge stays pending
    setPads(32'h0000_0008);
    setPads(32'h0);
    @(negedge clk); padIn = 32'h0000_0008;
    @(posedge clk); @(posedge clk);
    @(negedge clk); busAddr = 8'h30; busWrData = 32'h0000_0008; busWrEn = 1'b1;
    @(posedge clk); #1 busWrEn = 1'b0;
    mPad = 32'h0000_0008; mLatch = 32'h0000_0008;
    readCheck("R9 collision keeps pending", 8'h24);
    check("R9 collision status", expStatus(), 32'h8);
    busWrite(8'h30, 32'h0000_0008);
    readCheck("R9 plain ack clears", 8'h24);

    // Random phase
    for (int it = 0; it < 400; it++) begin
      int op;
      op = $urandom_range(0, 3);
      if (op == 0) setPads($urandom());
      else busWrite(wrOffs[$urandom_range(0, 15)], $urandom());
      if (it % 8 == 7) checkAll();
      else begin
        readCheck("R9 random status", 8'h24);
        checkIrq("R11 random irq");
      end
    end
    checkAll();

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule